// File: doc/BRIEF.md
# Two-Channel Serial/Parallel Unsigned Multiplier

This block multiplies two unsigned N-bit operands with a small, repeated bit-slice datapath instead of a full parallel array. One operand (the parallel operand) is held in a register for the whole operation. The other (the serial operand) is shifted out two bits per clock. In every cycle the even-indexed bit drives one row of AND gates and full adders, and the odd-indexed bit drives a second row. Carries stay in carry-save registers and are added in the next cycle, so two product bits leave the datapath per clock.

A one-cycle start pulse captures both operands while the block is idle. The block then runs for N clocks. During the first N/2 clocks it consumes the serial operand. During the last N/2 clocks it shifts in zeros, so that the stored sums and carries drain into the upper half of the product. An output collector assembles the 2N-bit result, and a one-cycle done pulse marks it valid. The result stays on the output until the next accepted start. A start that arrives while the block is busy is dropped.

Top module: `dcm_mul`

## Requirements
- R1: After reset, busy_o, done_o and product_o are all 0.
- R2: A start_i sampled high while busy_o is low captures par_op_i and ser_op_i and makes busy_o high from the following cycle.
- R3: done_o goes high N clock edges after the edge that accepted start, stays high for exactly one cycle, and busy_o is low whenever done_o is high.
- R4: While done_o is high, product_o equals the unsigned 2N-bit product par_op_i × ser_op_i of the captured operands.
- R5: A start_i raised while busy_o is high, with different operand values, has no effect: the running result, its done timing and the following idle state are unchanged.
- R6: While busy_o is low, product_o does not change, whatever values par_op_i and ser_op_i take.
- R7: Serial bit 2k is multiplied in the even-bit row and bit 2k+1 in the odd-bit row in the same cycle (k = 0 … N/2-1). A serial operand with only even bits set (…0101) and one with only odd bits set (…1010) each give the exact product.
- R8: Pending carries are flushed into the high bits: all-ones × all-ones gives (2^N−1)^2, and any operand × 0 gives 0.
- R9: A start_i sampled in the same cycle as done_o is accepted, and a new operation begins without an idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; accepted only while idle |
| par_op_i | input | N | Operand held in parallel |
| ser_op_i | input | N | Operand consumed two bits per cycle, LSB first |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | One-cycle pulse: product_o is valid |
| product_o | output | 2N | Unsigned product |

## Verification
The hardest case to reach is a carry chain that must still be draining during the zero-fill cycles. All-ones operands produce it, because they keep the carry-save registers full until the last shift. Those operands are applied on purpose, along with single-channel serial patterns, which load the even-bit row or the odd-bit row by itself. A start that collides with an operation is produced by raising start_i with inverted operands two cycles into a run. A start that coincides with done is produced by launching the next operation at the very sample where done_o is seen. Random operands fill in the rest, and a scoreboard queue compares each completion against a behavioural product.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef struct packed {
    logic c;
    logic s;
  } fa_t;

  function automatic fa_t full_add(input logic a, input logic b, input logic ci);
    fa_t r;
    r.s = a ^ b ^ ci;
    r.c = (a & b) | (a & ci) | (b & ci);
    return r;
  endfunction
endpackage

// File: rtl/dcm_serializer.sv
module dcm_serializer #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [N-1:0] op_i,
  output logic [1:0]   pair_o
);
  logic [N-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= op_i;
    else if (shift_i) sr_q <= {2'b00, sr_q[N-1:2]};
  end

  // bit 0 -> even row, bit 1 -> odd row; zeros follow once exhausted
  assign pair_o = sr_q[1:0];
endmodule

// File: rtl/dcm_cell_array.sv
module dcm_cell_array
  import dcm_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [N-1:0] y_i,
  input  logic [1:0]   pair_i,
  output logic [1:0]   bits_o
);
  // residual stays below 2^(N+2); one spare column absorbs the top
  localparam int NW = N + 3;

  logic [NW-1:0] s_q, c_q, s1, s2;
  logic [NW-2:0] k1, k2;
  logic          oc_q;
  logic [2:0]    low;

  for (genvar j = 0; j < NW; j++) begin : g_col
    logic pe, po, cin2;
    if (j < N) begin : g_pe
      assign pe = y_i[j] & pair_i[0];
    end else begin : g_pe0
      assign pe = 1'b0;
    end
    if (j >= 1 && j <= N) begin : g_po
      assign po = y_i[j-1] & pair_i[1];
    end else begin : g_po0
      assign po = 1'b0;
    end
    if (j >= 1) begin : g_ci
      assign cin2 = k1[j-1];
    end else begin : g_ci0
      assign cin2 = 1'b0;
    end
    if (j < NW - 1) begin : g_fa
      fa_t f1, f2;
      assign f1    = full_add(s_q[j], c_q[j], pe);
      assign s1[j] = f1.s;
      assign k1[j] = f1.c;
      assign f2    = full_add(s1[j], cin2, po);
      assign s2[j] = f2.s;
      assign k2[j] = f2.c;
    end else begin : g_top
      assign s1[j] = s_q[j] ^ c_q[j] ^ pe;
      assign s2[j] = s1[j] ^ cin2 ^ po;
    end
  end

  // resolve the two retiring columns; carry out re-enters next cycle
  assign low    = {1'b0, s2[1:0]} + {1'b0, k2[0], 1'b0} + {2'b00, oc_q};
  assign bits_o = low[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q  <= '0;
      c_q  <= '0;
      oc_q <= 1'b0;
    end else if (clr_i) begin
      s_q  <= '0;
      c_q  <= '0;
      oc_q <= 1'b0;
    end else if (en_i) begin
      s_q  <= {2'b00, s2[NW-1:2]};
      c_q  <= {2'b00, k2[NW-2:1]};
      oc_q <= low[2];
    end
  end
endmodule

// File: rtl/dcm_collector.sv
module dcm_collector #(
  parameter int N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [1:0]     bits_i,
  output logic [2*N-1:0] prod_o
);
  localparam int PW = 2 * N;

  logic [PW-1:0] prod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prod_q <= '0;
    else if (en_i) prod_q <= {bits_i, prod_q[PW-1:2]};
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/dcm_mul.sv
module dcm_mul #(
  parameter int N = 8  // must be even
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N-1:0]   par_op_i,
  input  logic [N-1:0]   ser_op_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*N-1:0] product_o
);
  localparam int CW = $clog2(N) + 1;

  logic          busy_q, done_q, accept, last;
  logic [CW-1:0] cnt_q;
  logic [N-1:0]  y_q;
  logic [1:0]    pair, bits;

  assign accept = start_i & ~busy_q;
  assign last   = busy_q & (cnt_q == CW'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      y_q    <= '0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        y_q    <= par_op_i;
      end else if (last) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  dcm_serializer #(.N(N)) i_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .shift_i (busy_q),
    .op_i    (ser_op_i),
    .pair_o  (pair)
  );

  dcm_cell_array #(.N(N)) i_arr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (busy_q),
    .y_i    (y_q),
    .pair_i (pair),
    .bits_o (bits)
  );

  dcm_collector #(.N(N)) i_col (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_q),
    .bits_i (bits),
    .prod_o (product_o)
  );

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/dcm_mul_chk.sv
module dcm_mul_chk #(
  parameter int N = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [N-1:0]   par_op_i,
  input logic [N-1:0]   ser_op_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*N-1:0] product_o
);
  localparam int LW = $clog2(N) + 2;

  logic [LW-1:0]  run_len;
  logic [2*N-1:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len <= '0;
      exp_q   <= '0;
    end else if (start_i && !busy_o) begin
      run_len <= '0;
      exp_q   <= {{N{1'b0}}, par_op_i} * {{N{1'b0}}, ser_op_i};
    end else if (busy_o) begin
      run_len <= run_len + 1'b1;
    end
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_len == LW'(N))); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R3
  AST_PRODUCT_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (product_o == exp_q)); // R4
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(product_o)); // R6
endmodule

bind dcm_mul dcm_mul_chk #(.N(N)) i_chk (.*);

// File: tb/test_dcm_mul.sv
`timescale 1ns/1ps
module test_dcm_mul;
  localparam int N  = 8;
  localparam int PW = 2 * N;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [N-1:0]  par_op_i = '0;
  logic [N-1:0]  ser_op_i = '0;
  logic          busy_o, done_o;
  logic [PW-1:0] product_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [PW-1:0] exp_q[$];
  logic [PW-1:0] last_exp = '0;

  always #2.5 clk_i = ~clk_i;

  dcm_mul #(.N(N)) i_dcm_mul (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [PW-1:0] mul(input logic [N-1:0] a, input logic [N-1:0] b);
    return {{N{1'b0}}, a} * {{N{1'b0}}, b};
  endfunction

  // scoreboard monitor (R4)
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected done", 64'(product_o), 0);
      end else begin
        logic [PW-1:0] e;
        e = exp_q.pop_front();
        check(product_o == e, "R4 product", 64'(product_o), 64'(e));
      end
    end
  end

  // called at a negedge with the block idle
  task automatic launch(input logic [N-1:0] y, input logic [N-1:0] x);
    exp_q.push_back(mul(y, x));
    last_exp = mul(y, x);
    par_op_i = y;
    ser_op_i = x;
    start_i  = 1'b1;
    @(negedge clk_i);
    start_i  = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", 64'(busy_o), 1);
  endtask

  task automatic wait_done(input bit poke);
    int lat = 0;
    while (!done_o && lat < 4 * N) begin
      @(negedge clk_i);
      lat++;
      if (poke && lat == 2) begin
        par_op_i = ~par_op_i;
        ser_op_i = ~ser_op_i;
        start_i  = 1'b1;
      end else begin
        start_i  = 1'b0;
      end
    end
    start_i = 1'b0;
    check(lat == N, poke ? "R5 latency with ignored start" : "R3 latency", 64'(lat), 64'(N));
    check(busy_o == 1'b0, "R3 idle at done", 64'(busy_o), 0);
  endtask

  task automatic run_op(input logic [N-1:0] y, input logic [N-1:0] x, input bit poke);
    launch(y, x);
    wait_done(poke);
    @(negedge clk_i);
    check(done_o == 1'b0, "R3 one-cycle done", 64'(done_o), 0);
    check(busy_o == 1'b0, poke ? "R5 no extra run" : "R3 stays idle", 64'(busy_o), 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(busy_o == 1'b0, "R1 busy", 64'(busy_o), 0);
    check(done_o == 1'b0, "R1 done", 64'(done_o), 0);
    check(product_o == '0, "R1 product", 64'(product_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R8 corners: carry flush and zero
    run_op('1, '1, 1'b0);
    run_op('0, '1, 1'b0);
    run_op('1, '0, 1'b0);
    run_op(N'(1), N'(1), 1'b0);
    // R7 channel isolation
    run_op('1, {(N/2){2'b01}}, 1'b0);
    run_op('1, {(N/2){2'b10}}, 1'b0);
    run_op(N'(8'hA7), {(N/2){2'b10}}, 1'b0);
    run_op(N'(8'h3C), {(N/2){2'b01}}, 1'b0);
    run_op({1'b1, {(N-1){1'b0}}}, {1'b1, {(N-1){1'b0}}}, 1'b0);

    // R5 start during busy is ignored
    run_op(N'(8'hC5), N'(8'h9B), 1'b1);
    run_op('1, '1, 1'b1);

    // R6 hold while idle with changing inputs
    for (int i = 0; i < 4; i++) begin
      par_op_i = N'($urandom);
      ser_op_i = N'($urandom);
      @(negedge clk_i);
      check(product_o == last_exp, "R6 idle hold", 64'(product_o), 64'(last_exp));
    end

    // R9 back-to-back: start in the done cycle
    launch(N'(8'h5A), N'(8'hE3));
    wait_done(1'b0);
    launch(N'(8'hFF), N'(8'h81));
    check(busy_o == 1'b1, "R9 back-to-back accept", 64'(busy_o), 1);
    wait_done(1'b0);
    @(negedge clk_i);

    // R4 random operands
    for (int i = 0; i < 40; i++) begin
      run_op(N'($urandom), N'($urandom), 1'b0);
    end

    check(exp_q.size() == 0, "R4 all results seen", 64'(exp_q.size()), 0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule